// File: doc/BRIEF.md
# Crystal Clock Loss Monitor

This block watches an external crystal clock from a free-running reference clock domain and decides when the crystal has slowed below a minimum frequency. If that happens, it raises a reset request and emits a one-cycle event that a flag register can capture. The monitored clock is brought into the reference domain through a synchronizer. A counter then measures how many reference cycles pass between consecutive rising edges of the monitored clock. If the gap is longer than the number of reference cycles in one period at the threshold frequency, the crystal is declared failed.

Some conditions halt the crystal on purpose. These are software stop mode and the state where the core clock is taken from the internal ring oscillator. Under either condition, and whenever the detector is disabled, the monitor never declares a failure. Whenever one of these suppressing conditions is entered or left, the gap counter restarts. This prevents a count left over from earlier from tripping the detector.

A failure holds the reset request high for a fixed number of reference cycles. The request is then released and the detector re-arms on its own. The gap limit is `REF_HZ / MIN_HZ` reference cycles and is called LIMIT below. With the default values the threshold is 20 kHz.

Top module: `osc_fail_monitor`

## Requirements
- R1: With the monitor armed, when no rising edge of `mon_clk` is seen for more than LIMIT consecutive reference cycles, a failure is declared. This covers the crystal clock held low and held high.
- R2: With the monitor armed and `mon_clk` toggling at a period of LIMIT reference cycles or fewer, no failure is ever declared. This includes a period of exactly LIMIT.
- R3: While `det_en` is 0, neither `fail_pulse` nor `fail_rst_req` is ever asserted.
- R4: While `stop_mode` is 1, neither output is ever asserted.
- R5: While `ring_sel` is 1, neither output is ever asserted.
- R6: `fail_pulse` is high for exactly one reference cycle per failure. It is high in the same cycle in which `fail_rst_req` rises.
- R7: `fail_rst_req` stays high for exactly HOLD_CYCLES reference cycles per failure.
- R8: After `fail_rst_req` falls, the detector re-arms. If `mon_clk` is still dead, the next request rises after exactly LIMIT reference cycles with the request low.
- R9: Take a dead `mon_clk` and a suppressing condition that is removed at a falling edge of `clk`. Any partial count from before is discarded. `fail_rst_req` is first seen high at the (LIMIT+2)-th following falling edge of `clk`.
- R10: While `rst` (synchronous, active high) is applied, and right after it, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Crystal clock under observation, asynchronous to `clk` |
| det_en | input | 1 | 1 arms the detector, 0 disables it |
| stop_mode | input | 1 | 1 while the crystal is halted deliberately by stop mode |
| ring_sel | input | 1 | 1 while the core runs from the internal ring oscillator |
| fail_rst_req | output | 1 | Reset request, held HOLD_CYCLES cycles after a failure |
| fail_pulse | output | 1 | One-cycle failure event for setting a flag |

## Verification
Two things can meet in one cycle. One is the arrival of a synchronized monitored edge. The other is the counter reaching its trip value. This happens when the crystal period equals LIMIT exactly. The bench sweeps the crystal period across LIMIT and judges each case by counting failure events: a period of exactly LIMIT must yield none, and LIMIT+1 must yield at least one. The other collision is between a restart caused by leaving a suppression condition and a stale count near the limit. The bench provokes it by removing stop mode partway through a dead gap and checks the exact latency of the first request.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

  function automatic int unsigned period_limit(input int unsigned ref_hz,
                                               input int unsigned min_hz);
    int unsigned q;
    q = ref_hz / min_hz;
    if (q < 2) q = 2;
    return q;
  endfunction

  function automatic int unsigned width_for(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/ofm_edge_sync.sv
module ofm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ofm_gap_timer.sv
module ofm_gap_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic trip
);
  localparam int unsigned CW   = ofm_pkg::width_for(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || restart)   gap_q <= '0;
    else if (gap_q != LAST) gap_q <= gap_q + 1'b1;
  end

  assign trip = ~restart & (gap_q == LAST);
endmodule

// File: rtl/ofm_hold_stretch.sv
module ofm_hold_stretch #(
  parameter int unsigned HOLD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  output logic req,
  output logic pulse
);
  localparam int unsigned HW = ofm_pkg::width_for(HOLD);
  localparam logic [HW-1:0] HEND = HW'(HOLD - 1);

  logic [HW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      pulse  <= 1'b0;
      held_q <= '0;
    end else begin
      pulse <= trip & ~req;
      if (!req) begin
        if (trip) begin
          req    <= 1'b1;
          held_q <= '0;
        end
      end else if (held_q == HEND) begin
        req <= 1'b0;
      end else begin
        held_q <= held_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_fail_monitor.sv
module osc_fail_monitor #(
  parameter int unsigned REF_HZ      = 50_000_000,
  parameter int unsigned MIN_HZ      = 20_000,
  parameter int unsigned HOLD_CYCLES = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  input  logic det_en,
  input  logic stop_mode,
  input  logic ring_sel,
  output logic fail_rst_req,
  output logic fail_pulse
);
  localparam int unsigned LIMIT = ofm_pkg::period_limit(REF_HZ, MIN_HZ);

  logic mon_rise;
  logic armed_q;
  logic armed_prev_q;
  logic restart;
  logic trip;

  ofm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (mon_clk),
    .rise     (mon_rise)
  );

  // Armed only when enabled and no deliberate clock halt is in effect.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q      <= 1'b0;
      armed_prev_q <= 1'b0;
    end else begin
      armed_q      <= det_en & ~stop_mode & ~ring_sel;
      armed_prev_q <= armed_q;
    end
  end

  // Any change of arming, a monitored edge or an active request clears the gap.
  assign restart = ~armed_q | (armed_q ^ armed_prev_q) | mon_rise | fail_rst_req;

  ofm_gap_timer #(.LIMIT(LIMIT)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .trip    (trip)
  );

  ofm_hold_stretch #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .trip  (trip),
    .req   (fail_rst_req),
    .pulse (fail_pulse)
  );
endmodule

// File: rtl/ofm_checker.sv
module ofm_checker #(
  parameter int unsigned HOLD = 64
) (
  input logic clk,
  input logic rst,
  input logic det_en,
  input logic stop_mode,
  input logic ring_sel,
  input logic fail_rst_req,
  input logic fail_pulse
);
  logic [31:0] high_len_q;
  logic        quiet;

  always_ff @(posedge clk) begin
    if (rst)               high_len_q <= '0;
    else if (fail_rst_req) high_len_q <= high_len_q + 1;
    else                   high_len_q <= '0;
  end

  assign quiet = ~det_en | stop_mode | ring_sel;

  // R6: event and request rise together
  p_pulse_with_rise_r6: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |-> (fail_rst_req && !$past(fail_rst_req)));

  // R6: request rise carries the event
  p_rise_has_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_rst_req) |-> fail_pulse);

  // R6: one cycle wide
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |=> !fail_pulse);

  // R7: request width
  p_hold_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_rst_req) |-> (high_len_q == HOLD));

  // R3 R4 R5: suppression blocks new events
  p_quiet_no_event_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(quiet, 1) && $past(quiet, 2)) |-> !fail_pulse);
endmodule

bind osc_fail_monitor ofm_checker #(.HOLD(HOLD_CYCLES)) u_ofm_chk (
  .clk          (clk),
  .rst          (rst),
  .det_en       (det_en),
  .stop_mode    (stop_mode),
  .ring_sel     (ring_sel),
  .fail_rst_req (fail_rst_req),
  .fail_pulse   (fail_pulse)
);

// File: tb/osc_fail_monitor_test.sv
`timescale 1ns/1ps
module osc_fail_monitor_test;
  localparam int REF_HZ = 1200;
  localparam int MIN_HZ = 100;
  localparam int HOLD   = 5;
  localparam int LIMIT  = REF_HZ / MIN_HZ;

  logic clk = 1'b0;
  logic rst, mon_clk, det_en, stop_mode, ring_sel;
  logic fail_rst_req, fail_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int req_samples = 0;
  bit gen_on = 1'b0;
  logic mon_hold = 1'b0;
  int gen_period = 4;
  int ph = 0;

  always #10 clk = ~clk;

  osc_fail_monitor #(.REF_HZ(REF_HZ), .MIN_HZ(MIN_HZ), .HOLD_CYCLES(HOLD),
                     .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .det_en(det_en),
    .stop_mode(stop_mode), .ring_sel(ring_sel),
    .fail_rst_req(fail_rst_req), .fail_pulse(fail_pulse));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // crystal generator
  initial begin
    mon_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        mon_clk = (ph < gen_period / 2);
        ph = (ph + 1 >= gen_period) ? 0 : ph + 1;
      end else begin
        mon_clk = mon_hold;
        ph = 0;
      end
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (fail_pulse) pulses++;
    if (fail_rst_req) req_samples++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic quiet_run(input string tag, input bit en, input bit stp, input bit ring);
    gen_on = 1'b0; mon_hold = 1'b0;
    det_en = en; stop_mode = stp; ring_sel = ring;
    do_reset();
    pulses = 0; req_samples = 0;
    repeat (6 * LIMIT) @(negedge clk);
    check(pulses == 0 && req_samples == 0, tag, pulses + req_samples, 0);
  endtask

  initial begin
    int k;
    rst = 1'b1; det_en = 1'b1; stop_mode = 1'b0; ring_sel = 1'b0;
    repeat (3) @(negedge clk);
    check(fail_rst_req == 1'b0, "R10 req in reset", fail_rst_req, 0);
    check(fail_pulse == 1'b0, "R10 pulse in reset", fail_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(fail_rst_req == 1'b0 && fail_pulse == 1'b0, "R10 after reset",
          fail_rst_req + fail_pulse, 0);

    // R1 R2: period sweep across the limit
    for (int p = 2; p <= LIMIT + 3; p++) begin
      det_en = 1'b1; stop_mode = 1'b0; ring_sel = 1'b0;
      gen_period = p; gen_on = 1'b1;
      do_reset();
      pulses = 0;
      repeat (6 * LIMIT) @(negedge clk);
      if (p <= LIMIT) check(pulses == 0, $sformatf("R2 period %0d", p), pulses, 0);
      else            check(pulses > 0, $sformatf("R1 period %0d", p), pulses, 1);
    end

    // R1: stuck high crystal
    gen_on = 1'b0; mon_hold = 1'b1;
    do_reset();
    pulses = 0;
    repeat (3 * LIMIT) @(negedge clk);
    check(pulses > 0, "R1 stuck high", pulses, 1);

    quiet_run("R3 detector disabled", 1'b0, 1'b0, 1'b0);
    quiet_run("R4 stop mode", 1'b1, 1'b1, 1'b0);
    quiet_run("R5 ring oscillator", 1'b1, 1'b0, 1'b1);

    // R9: stale count discarded after leaving stop mode
    gen_on = 1'b0; mon_hold = 1'b0;
    det_en = 1'b1; stop_mode = 1'b0; ring_sel = 1'b0;
    do_reset();
    repeat (LIMIT / 2 + 3) @(negedge clk);
    stop_mode = 1'b1;
    repeat (10) @(negedge clk);
    stop_mode = 1'b0;
    k = 0;
    while (!fail_rst_req && k < 4 * LIMIT) begin
      @(negedge clk);
      k++;
    end
    check(k == LIMIT + 2, "R9 first request latency", k, LIMIT + 2);

    // R6: event one cycle, aligned with request rise
    check(fail_pulse == 1'b1, "R6 pulse at rise", fail_pulse, 1);
    k = 1;
    @(negedge clk);
    check(fail_pulse == 1'b0, "R6 pulse single", fail_pulse, 0);
    while (fail_rst_req && k < 4 * HOLD) begin
      k++;
      @(negedge clk);
    end
    k = fail_rst_req ? k + 1 : k;
    check(k == HOLD, "R7 request width", k, HOLD);

    // R8: re-arm with dead crystal
    k = 0;
    while (!fail_rst_req && k < 4 * LIMIT) begin
      k++;
      @(negedge clk);
    end
    check(k == LIMIT, "R8 low gap before re-trip", k, LIMIT);
    check(fail_pulse == 1'b1, "R8 re-trip event", fail_pulse, 1);

    finish_run();
  end
endmodule